// File: doc/BRIEF.md
# Subrate Byte Assembler

This block builds outgoing time-slot bytes for a TDM switch from pieces of incoming bytes. Transfers on the shared bus always move whole bytes, so low-rate channels have to be packed into one byte before they go out: a nibble carries a 32 kbit/s channel, a dibit a 16 kbit/s channel and a single bit an 8 kbit/s channel. One output byte may hold any mix of these pieces. Bit positions that no piece covers are don't-care and are sent as 1.

Each output slot has a small table of fragment descriptors. A descriptor names a source slot in the current frame, a bit offset within that source byte, a fragment size, a destination offset in the output byte and an enable flag. Software writes descriptors through a plain write port. A whole frame of source bytes enters on a valid/ready stream. The block then produces one assembled byte per output slot, in slot order, on a valid/ready output stream. Each output byte comes with a per-descriptor error mask that marks descriptors which were enabled but rejected.

Back-pressure rules: `in_ready` is high only while no frame is being assembled. A frame is taken on a cycle where `in_valid` and `in_ready` are both high. An output byte is held unchanged for as long as `out_valid` is high and `out_ready` is low. Each output byte takes one cycle to assemble, so a byte is always ready within one slot period.

Top module: `sra_byte_assembler`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and every descriptor is disabled. A frame assembled with no descriptor written gives 8'hFF for every slot, with an error mask of 0.
- R2: The size code is 2'b00 for one bit, 2'b01 for a dibit and 2'b10 for a nibble. An accepted fragment of width w copies bits [src_off +: w] of source byte `src_slot` into output bits [dst_off +: w] and keeps their order. Source slot k occupies `in_frame[8k +: 8]`.
- R3: Every output bit that no accepted fragment covers is driven as 1.
- R4: An enabled descriptor with size code 2'b11 sets its bit in `out_err` and does not change the output byte.
- R5: An enabled descriptor is rejected if either offset is not a multiple of its width (dibits at 0, 2, 4 or 6; nibbles at 0 or 4) or if its source slot is beyond the frame. A rejected descriptor sets its `out_err` bit and does not change the output byte.
- R6: Descriptors are taken in index order, lowest first. A descriptor whose destination bits overlap bits already claimed by an accepted lower-index descriptor is rejected, sets its `out_err` bit and does not change the output byte.
- R7: A disabled descriptor never sets its `out_err` bit and never changes the output byte.
- R8: `in_ready` falls in the cycle after a frame is taken. The byte for slot 0 becomes valid one cycle after that. Bytes come out for slots 0 to NUM_SLOTS-1 in order, and `out_last` is high only with slot NUM_SLOTS-1.
- R9: While `out_valid` is high and `out_ready` is low, `out_byte`, `out_slot`, `out_err` and `out_last` do not change.
- R10: After an output handshake on a byte that is not the last, the next slot's byte is valid in the very next cycle.
- R11: A descriptor write addressed by (`cfg_slot`, `cfg_idx`) is used for every byte assembled after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_slot | input | SLOT_W | Output slot of the descriptor being written |
| cfg_idx | input | IDX_W | Descriptor index within the slot |
| cfg_valid | input | 1 | Descriptor enable |
| cfg_size | input | 2 | Fragment size code |
| cfg_src_slot | input | SRC_W | Source slot within the frame |
| cfg_src_off | input | 3 | Bit offset in the source byte |
| cfg_dst_off | input | 3 | Bit offset in the output byte |
| in_valid | input | 1 | Frame valid |
| in_ready | output | 1 | Frame accepted when high |
| in_frame | input | NUM_SRC*8 | Source bytes, slot k at bits [8k +: 8] |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_byte | output | 8 | Assembled byte |
| out_slot | output | SLOT_W | Output slot number of `out_byte` |
| out_last | output | 1 | Last slot of the frame |
| out_err | output | NUM_FRAG | Enabled descriptors that were rejected |

## Verification
A corrupted descriptor entry or a wrong claim chain shows up in the very byte it feeds. It appears as a wrong data bit, a 1 where data belonged, or a wrong `out_err` bit, and it can be seen one cycle after that slot is assembled. A wrong slot counter or busy flag shows at once as a skipped or repeated `out_slot`, a misplaced `out_last`, or `in_ready` being high during assembly. A fault in the output register under back-pressure shows as an output change while `out_ready` is low. Random descriptors, many of them misaligned or overlapping, are checked byte by byte against a model built from the rules above.

// File: rtl/sra_pkg.sv
package sra_pkg;

  typedef enum logic [1:0] {
    SZ_BIT    = 2'b00,
    SZ_DIBIT  = 2'b01,
    SZ_NIBBLE = 2'b10,
    SZ_RSVD   = 2'b11
  } frag_size_e;

  typedef struct packed {
    logic       valid;
    frag_size_e size;
    logic [2:0] src_off;
    logic [2:0] dst_off;
  } frag_desc_t;

  // Low-aligned mask covering the fragment width; zero for the reserved code.
  function automatic logic [7:0] width_mask(frag_size_e sz);
    case (sz)
      SZ_BIT:    return 8'h01;
      SZ_DIBIT:  return 8'h03;
      SZ_NIBBLE: return 8'h0F;
      default:   return 8'h00;
    endcase
  endfunction

  // Offset bits that must be zero for an aligned fragment.
  function automatic logic [2:0] align_bits(frag_size_e sz);
    case (sz)
      SZ_BIT:    return 3'b000;
      SZ_DIBIT:  return 3'b001;
      default:   return 3'b011;
    endcase
  endfunction

endpackage

// File: rtl/sra_desc_store.sv
module sra_desc_store
  import sra_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_FRAG  = 8,
  parameter int SRC_W     = 3,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int IDX_W    = (NUM_FRAG > 1) ? $clog2(NUM_FRAG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [IDX_W-1:0]  wr_idx,
  input  frag_desc_t        wr_desc,
  input  logic [SRC_W-1:0]  wr_src,
  input  logic [SLOT_W-1:0] rd_slot,
  output frag_desc_t        rd_desc [NUM_FRAG],
  output logic [SRC_W-1:0]  rd_src  [NUM_FRAG]
);

  frag_desc_t       desc_q [NUM_SLOTS][NUM_FRAG];
  logic [SRC_W-1:0] src_q  [NUM_SLOTS][NUM_FRAG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        for (int f = 0; f < NUM_FRAG; f++) begin
          desc_q[s][f] <= '0;
          src_q[s][f]  <= '0;
        end
      end
    end else if (wr_en) begin
      desc_q[wr_slot][wr_idx] <= wr_desc;
      src_q[wr_slot][wr_idx]  <= wr_src;
    end
  end

  generate
    for (genvar f = 0; f < NUM_FRAG; f++) begin : g_rd
      assign rd_desc[f] = desc_q[rd_slot][f];
      assign rd_src[f]  = src_q[rd_slot][f];
    end
  endgenerate

  // R11: a write lands in the addressed entry by the next cycle
  p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (desc_q[$past(wr_slot)][$past(wr_idx)] == $past(wr_desc)));

endmodule

// File: rtl/sra_frag_lane.sv
module sra_frag_lane
  import sra_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SRC_W   = 3
) (
  input  frag_desc_t         desc,
  input  logic [SRC_W-1:0]   src_idx,
  input  logic [NUM_SRC*8-1:0] frame,
  output logic               ok,
  output logic [7:0]         mask,
  output logic [7:0]         data
);

  logic [7:0] wmask;
  logic [7:0] sel;
  logic       aligned;
  logic       in_range;

  always_comb begin
    wmask    = width_mask(desc.size);
    aligned  = ((desc.src_off & align_bits(desc.size)) == 3'b000) &&
               ((desc.dst_off & align_bits(desc.size)) == 3'b000);
    in_range = (32'(src_idx) < NUM_SRC);
    sel      = in_range ? frame[{src_idx, 3'b000} +: 8] : 8'h00;
    ok       = desc.valid && (desc.size != SZ_RSVD) && aligned && in_range;
    mask     = ok ? (wmask << desc.dst_off) : 8'h00;
    data     = ok ? (((sel >> desc.src_off) & wmask) << desc.dst_off) : 8'h00;
  end

endmodule

// File: rtl/sra_merge.sv
module sra_merge #(
  parameter int NUM_FRAG = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_FRAG-1:0] present,
  input  logic [NUM_FRAG-1:0] ok,
  input  logic [7:0]          mask [NUM_FRAG],
  input  logic [7:0]          data [NUM_FRAG],
  output logic [7:0]          byte_out,
  output logic [NUM_FRAG-1:0] err
);

  logic [7:0]          claim [NUM_FRAG+1];
  logic [7:0]          acc   [NUM_FRAG+1];
  logic [NUM_FRAG-1:0] take;

  assign claim[0] = 8'h00;
  assign acc[0]   = 8'h00;

  generate
    for (genvar g = 0; g < NUM_FRAG; g++) begin : g_chain
      assign take[g]    = ok[g] && ((mask[g] & claim[g]) == 8'h00);
      assign claim[g+1] = claim[g] | (take[g] ? mask[g] : 8'h00);
      assign acc[g+1]   = acc[g]   | (take[g] ? data[g] : 8'h00);
      assign err[g]     = present[g] && !take[g];
    end
  endgenerate

  // Unclaimed positions are don't-care, sent as ones.
  assign byte_out = acc[NUM_FRAG] | ~claim[NUM_FRAG];

  int taken_bits;
  always_comb begin
    taken_bits = 0;
    for (int i = 0; i < NUM_FRAG; i++)
      if (take[i]) taken_bits += $countones(mask[i]);
  end

  // R6: accepted fragments never share a destination bit
  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(claim[NUM_FRAG]) == taken_bits);

endmodule

// File: rtl/sra_byte_assembler.sv
module sra_byte_assembler
  import sra_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_FRAG  = 8,
  parameter int NUM_SRC   = 8,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int IDX_W    = (NUM_FRAG > 1) ? $clog2(NUM_FRAG) : 1,
  localparam int SRC_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [SLOT_W-1:0]    cfg_slot,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic                 cfg_valid,
  input  logic [1:0]           cfg_size,
  input  logic [SRC_W-1:0]     cfg_src_slot,
  input  logic [2:0]           cfg_src_off,
  input  logic [2:0]           cfg_dst_off,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [NUM_SRC*8-1:0] in_frame,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [7:0]           out_byte,
  output logic [SLOT_W-1:0]    out_slot,
  output logic                 out_last,
  output logic [NUM_FRAG-1:0]  out_err
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  logic                 busy;
  logic [SLOT_W-1:0]    cnt;
  logic [NUM_SRC*8-1:0] frame_q;

  frag_desc_t           wr_desc;
  frag_desc_t           lane_desc [NUM_FRAG];
  logic [SRC_W-1:0]     lane_src  [NUM_FRAG];
  logic [NUM_FRAG-1:0]  lane_ok;
  logic [NUM_FRAG-1:0]  lane_present;
  logic [7:0]           lane_mask [NUM_FRAG];
  logic [7:0]           lane_data [NUM_FRAG];
  logic [7:0]           asm_byte;
  logic [NUM_FRAG-1:0]  asm_err;

  assign wr_desc = '{valid: cfg_valid, size: frag_size_e'(cfg_size),
                     src_off: cfg_src_off, dst_off: cfg_dst_off};

  sra_desc_store #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_FRAG(NUM_FRAG), .SRC_W(SRC_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_slot(cfg_slot),
    .wr_idx(cfg_idx), .wr_desc(wr_desc), .wr_src(cfg_src_slot),
    .rd_slot(cnt), .rd_desc(lane_desc), .rd_src(lane_src)
  );

  generate
    for (genvar f = 0; f < NUM_FRAG; f++) begin : g_lane
      sra_frag_lane #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_lane (
        .desc(lane_desc[f]), .src_idx(lane_src[f]), .frame(frame_q),
        .ok(lane_ok[f]), .mask(lane_mask[f]), .data(lane_data[f])
      );
      assign lane_present[f] = lane_desc[f].valid;
    end
  endgenerate

  sra_merge #(.NUM_FRAG(NUM_FRAG)) u_merge (
    .clk(clk), .rst_n(rst_n), .present(lane_present), .ok(lane_ok),
    .mask(lane_mask), .data(lane_data), .byte_out(asm_byte), .err(asm_err)
  );

  assign in_ready = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      frame_q   <= '0;
      out_valid <= 1'b0;
      out_byte  <= 8'h00;
      out_slot  <= '0;
      out_last  <= 1'b0;
      out_err   <= '0;
    end else begin
      if (in_valid && in_ready) begin
        frame_q <= in_frame;
        busy    <= 1'b1;
        cnt     <= '0;
      end
      if (busy && (!out_valid || out_ready)) begin
        out_valid <= 1'b1;
        out_byte  <= asm_byte;
        out_err   <= asm_err;
        out_slot  <= cnt;
        out_last  <= (cnt == LAST_SLOT);
        if (cnt == LAST_SLOT) busy <= 1'b0;
        else                  cnt  <= cnt + 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R9: a stalled output holds every field
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) &&
      $stable(out_slot) && $stable(out_err) && $stable(out_last)));

  // R10: back-to-back slots within a frame
  p_next_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=>
      (out_valid && out_slot == $past(out_slot) + 1'b1));

  // R8: frame input closes after acceptance
  p_in_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R8: last flag only on the final slot
  p_last_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (out_slot == LAST_SLOT));

endmodule

// File: tb/tb_sra_byte_assembler.sv
module tb_sra_byte_assembler;

  localparam int NUM_SLOTS = 4;
  localparam int NUM_FRAG  = 8;
  localparam int NUM_SRC   = 8;
  localparam int SLOT_W    = 2;
  localparam int IDX_W     = 3;
  localparam int SRC_W     = 3;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 cfg_we = 1'b0;
  logic [SLOT_W-1:0]    cfg_slot = '0;
  logic [IDX_W-1:0]     cfg_idx = '0;
  logic                 cfg_valid = 1'b0;
  logic [1:0]           cfg_size = '0;
  logic [SRC_W-1:0]     cfg_src_slot = '0;
  logic [2:0]           cfg_src_off = '0;
  logic [2:0]           cfg_dst_off = '0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic [NUM_SRC*8-1:0] in_frame = '0;
  logic                 out_valid;
  logic                 out_ready = 1'b0;
  logic [7:0]           out_byte;
  logic [SLOT_W-1:0]    out_slot;
  logic                 out_last;
  logic [NUM_FRAG-1:0]  out_err;

  always #5 clk = ~clk;

  sra_byte_assembler #(.NUM_SLOTS(NUM_SLOTS), .NUM_FRAG(NUM_FRAG), .NUM_SRC(NUM_SRC)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_idx(cfg_idx),
    .cfg_valid(cfg_valid), .cfg_size(cfg_size), .cfg_src_slot(cfg_src_slot),
    .cfg_src_off(cfg_src_off), .cfg_dst_off(cfg_dst_off), .in_valid(in_valid),
    .in_ready(in_ready), .in_frame(in_frame), .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .out_slot(out_slot), .out_last(out_last), .out_err(out_err)
  );

  // Bench copy of the descriptor table
  bit       m_valid [NUM_SLOTS][NUM_FRAG];
  int       m_size  [NUM_SLOTS][NUM_FRAG];
  int       m_src   [NUM_SLOTS][NUM_FRAG];
  int       m_soff  [NUM_SLOTS][NUM_FRAG];
  int       m_doff  [NUM_SLOTS][NUM_FRAG];
  int       n_checks = 0;
  int       n_fails  = 0;
  int       ready_pct = 70;

  task automatic chk(input bit good, input string tag, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!good) begin
      n_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Expected byte and error mask from the requirement rules (R2..R7)
  function automatic void model(input int s, input logic [NUM_SRC*8-1:0] fr,
                                output logic [7:0] b, output logic [NUM_FRAG-1:0] e);
    logic [7:0] used = 8'h00;
    logic [7:0] val  = 8'h00;
    e = '0;
    for (int i = 0; i < NUM_FRAG; i++) begin
      int w;
      logic [7:0] m;
      logic [7:0] piece;
      if (!m_valid[s][i]) continue;
      w = (m_size[s][i] == 0) ? 1 : (m_size[s][i] == 1) ? 2 : (m_size[s][i] == 2) ? 4 : 0;
      if (w == 0 || (m_soff[s][i] % w) != 0 || (m_doff[s][i] % w) != 0 || m_src[s][i] >= NUM_SRC) begin
        e[i] = 1'b1;
        continue;
      end
      m = 8'(((1 << w) - 1) << m_doff[s][i]);
      if ((m & used) != 0) begin
        e[i] = 1'b1;
        continue;
      end
      used  = used | m;
      piece = fr[m_src[s][i]*8 +: 8] >> m_soff[s][i];
      val   = val | (8'((piece & 8'((1 << w) - 1)) << m_doff[s][i]));
    end
    b = val | ~used;
  endfunction

  task automatic cfg(input int s, input int i, input bit v, input int sz,
                     input int src, input int so, input int dof);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slot = SLOT_W'(s); cfg_idx = IDX_W'(i); cfg_valid = v;
    cfg_size = 2'(sz); cfg_src_slot = SRC_W'(src); cfg_src_off = 3'(so); cfg_dst_off = 3'(dof);
    m_valid[s][i] = v; m_size[s][i] = sz; m_src[s][i] = src; m_soff[s][i] = so; m_doff[s][i] = dof;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_all();
    for (int s = 0; s < NUM_SLOTS; s++)
      for (int i = 0; i < NUM_FRAG; i++)
        cfg(s, i, 1'b0, 0, 0, 0, 0);
  endtask

  // Send a frame and collect every slot byte, checking against the model
  task automatic run_frame(input logic [NUM_SRC*8-1:0] fr, input string tag);
    int  got = 0;
    bit  first = 1'b1;
    bit  holding = 1'b0;
    bit  prev_hs = 1'b0;
    logic [7:0] hold_b;
    logic [NUM_FRAG-1:0] hold_e;
    int  hold_s;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_frame = fr;
    chk(in_ready == 1'b1, "R8", "in_ready idle", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0 && out_valid == 1'b0, "R8", "busy after take",
        {in_ready, out_valid}, 0);
    while (got < NUM_SLOTS) begin
      bit rdy;
      @(negedge clk);
      if (first) begin
        chk(out_valid == 1'b1, "R8", "slot0 latency", out_valid, 1);
        first = 1'b0;
      end
      if (prev_hs) chk(out_valid == 1'b1, "R10", "back-to-back", out_valid, 1);
      if (holding) begin
        chk(out_valid && out_byte == hold_b && out_err == hold_e && int'(out_slot) == hold_s,
            "R9", "stall hold", out_byte, hold_b);
      end
      rdy = (($urandom % 100) < ready_pct);
      out_ready = rdy;
      prev_hs = 1'b0;
      holding = 1'b0;
      if (out_valid) begin
        if (rdy) begin
          logic [7:0] eb;
          logic [NUM_FRAG-1:0] ee;
          model(got, fr, eb, ee);
          chk(int'(out_slot) == got, "R8", "slot order", out_slot, got);
          chk(out_last == (got == NUM_SLOTS - 1), "R8", "last flag", out_last, got == NUM_SLOTS - 1);
          chk(out_byte == eb, tag, $sformatf("byte slot %0d", got), out_byte, eb);
          chk(out_err == ee, tag, $sformatf("err slot %0d", got), out_err, ee);
          prev_hs = (got != NUM_SLOTS - 1);
          got++;
        end else begin
          holding = 1'b1; hold_b = out_byte; hold_e = out_err; hold_s = int'(out_slot);
        end
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  function automatic logic [NUM_SRC*8-1:0] rnd_frame();
    logic [NUM_SRC*8-1:0] f;
    for (int k = 0; k < NUM_SRC; k++) f[k*8 +: 8] = 8'($urandom);
    return f;
  endfunction

  initial begin
    for (int s = 0; s < NUM_SLOTS; s++)
      for (int i = 0; i < NUM_FRAG; i++) begin
        m_valid[s][i] = 0; m_size[s][i] = 0; m_src[s][i] = 0; m_soff[s][i] = 0; m_doff[s][i] = 0;
      end
    void'($urandom(32'h5AB1_0C3E));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1", "reset ports", {out_valid, in_ready}, 1);
    // R1, R3, R7: empty table gives all ones and no errors
    run_frame(rnd_frame(), "R1_R3");

    // R2: nibbles from two sources
    cfg(0, 0, 1, 2, 1, 4, 0);
    cfg(0, 1, 1, 2, 2, 0, 4);
    // R2: four dibits from different sources
    cfg(1, 0, 1, 1, 0, 6, 0);
    cfg(1, 1, 1, 1, 3, 2, 2);
    cfg(1, 2, 1, 1, 5, 0, 4);
    cfg(1, 3, 1, 1, 7, 4, 6);
    // R3, R4, R5: bits with fill, reserved size, misaligned dibit
    cfg(2, 0, 1, 0, 4, 7, 1);
    cfg(2, 1, 1, 0, 6, 3, 5);
    cfg(2, 2, 1, 3, 1, 0, 0);
    cfg(2, 3, 1, 1, 2, 1, 2);
    cfg(2, 4, 1, 2, 2, 0, 6);
    // R7: disabled misaligned descriptor stays silent
    cfg(2, 5, 0, 1, 3, 3, 3);
    // R6: overlap, lower index wins
    cfg(3, 0, 1, 2, 0, 0, 0);
    cfg(3, 1, 1, 0, 1, 5, 2);
    cfg(3, 2, 1, 0, 1, 5, 7);
    cfg(3, 3, 1, 1, 4, 2, 6);
    run_frame({8'h81, 8'h7E, 8'hC3, 8'h3C, 8'hA5, 8'h5A, 8'hF0, 8'h0F}, "R2_R4_R5_R6");
    ready_pct = 30;
    run_frame(rnd_frame(), "R2_R9");

    // R11: rewrite one descriptor and see it take effect
    cfg(0, 0, 1, 0, 6, 2, 3);
    ready_pct = 100;
    run_frame(rnd_frame(), "R11");

    // Random descriptor mixes
    for (int fr = 0; fr < 60; fr++) begin
      int nw;
      ready_pct = 40 + int'($urandom % 61);
      if (fr % 15 == 0) clear_all();
      nw = 1 + int'($urandom % 8);
      for (int k = 0; k < nw; k++) begin
        int sz, so, dof;
        sz  = int'($urandom % 4);
        so  = int'($urandom % 8);
        dof = int'($urandom % 8);
        if (($urandom % 4) != 0 && sz != 3) begin
          int w;
          w = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
          so = so - (so % w); dof = dof - (dof % w);
        end
        cfg(int'($urandom % NUM_SLOTS), int'($urandom % NUM_FRAG), ($urandom % 5) != 0,
            sz, int'($urandom % NUM_SRC), so, dof);
      end
      run_frame(rnd_frame(), "R2_R11_rand");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule